// File: doc/BRIEF.md
# SPI Master Bit-Clock Prescaler

This block turns the system clock into the bit-clock timing for an SPI master. While its `run` input is high, it counts system clocks and emits a single-cycle `half_tick` at the end of each SCK half period. The registered `sck` level toggles in that same cycle. Two further pulses mark the half periods that leave SCK high (`rise_tick`) and low (`fall_tick`). The shift engine that sits next to it decides which of these edges sample data and which shift it.

The half period is set by three inputs: a 4-bit modulus `cfg_pm`, a family-select bit `cfg_fast` and a sixteen-fold slowdown bit `cfg_div16`.

- With `cfg_fast` low, the full SCK period is 4·(PM+1) system clocks.
- With `cfg_fast` high, the full SCK period is 2·(PM+1) system clocks.
- `cfg_div16` multiplies either ratio by 16.

The configuration, the idle level `cfg_cpol` included, is captured on every clock edge at which `run` is low and is held frozen while `run` is high. When `run` drops, the counter clears and SCK returns to its idle level, so every transfer starts with a full half period.

Top module: `spi_sck_prescaler`

## Requirements
- R1: After reset, `sck`, `half_tick`, `rise_tick` and `fall_tick` are all 0 until the first edge at which `run` is sampled low.
- R2: At every clock edge where `run` is low, `sck` takes the value of `cfg_cpol`, and no tick pulse (`half_tick`, `rise_tick`, `fall_tick`) is produced.
- R3: With `cfg_fast`=0 and `cfg_div16`=0, consecutive `half_tick` pulses are 2·(PM+1) clocks apart.
- R4: With `cfg_fast`=1 and `cfg_div16`=0, consecutive `half_tick` pulses are PM+1 clocks apart. At PM=0 a pulse occurs in every cycle, so SCK runs at clock/2.
- R5: `cfg_div16`=1 multiplies the spacing of R3 or R4 by 16.
- R6: While running, `sck` changes value exactly in the cycles where `half_tick` is high. Each pulse lasts one cycle, except at PM=0 with `cfg_fast`=1.
- R7: `rise_tick` is high exactly when `half_tick` is high and `sck` is 1. `fall_tick` is high exactly when `half_tick` is high and `sck` is 0. The two are never high together.
- R8: If `run` is first sampled high at edge 1, the first `half_tick` appears after edge h, where h is the half period from R3–R5.
- R9: Lowering `run` mid-period clears the count, so after `run` rises again the first `half_tick` again comes a full h edges later.
- R10: The configuration used while running is the one present at the last edge where `run` was low. Changes to `cfg_*` while `run` is high have no effect on spacing or on level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | High to generate SCK, low to idle |
| cfg_pm | input | 4 | Prescale modulus PM |
| cfg_fast | input | 1 | 1: period 2·(PM+1); 0: period 4·(PM+1) |
| cfg_div16 | input | 1 | Extra ×16 slowdown |
| cfg_cpol | input | 1 | Idle SCK level |
| half_tick | output | 1 | One-cycle pulse per SCK half period |
| sck | output | 1 | Current SCK level |
| rise_tick | output | 1 | Half-tick that made SCK high |
| fall_tick | output | 1 | Half-tick that made SCK low |

## Verification
The bench measures tick spacing at the extremes of the ratio range: one cycle (PM=0 in the fast family) and 512 cycles (PM=15, slow family, ×16). A design that mixed up the families, or that applied the ×16 to the wrong term, would show a wrong spacing in these measurements. It also drops `run` in the middle of a half period and checks that the restart waits a full half period. A design that kept its count would tick early here. Finally, it changes every configuration input while running. A design that did not freeze its configuration would change speed or SCK level mid-transfer.

// File: rtl/spi_pscl_pkg.sv
package spi_pscl_pkg;
    parameter int PSC_PM_W = 4;

    typedef struct packed {
        logic [PSC_PM_W-1:0] pm;
        logic                fast;
        logic                div16;
        logic                cpol;
    } pscl_cfg_t;
endpackage

// File: rtl/spi_pscl_ratio.sv
module spi_pscl_ratio
    import spi_pscl_pkg::*;
#(
    parameter int DIV_EXP = 4,
    parameter int CNT_W   = PSC_PM_W + DIV_EXP + 2
) (
    input  pscl_cfg_t        cfg,
    output logic [CNT_W-1:0] half_m1
);
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] half;

    always_comb begin
        base = CNT_W'(cfg.pm) + CNT_W'(1);
        // The slow family has twice the half period of the fast one.
        half = cfg.fast ? base : (base << 1);
        if (cfg.div16) begin
            half = half << DIV_EXP;
        end
        half_m1 = half - CNT_W'(1);
    end
endmodule

// File: rtl/spi_pscl_counter.sv
module spi_pscl_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half_m1,
    output logic             wrap,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = run && (st_q.cnt == half_m1);
        st_d.tick = wrap;
        if (!run || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> st_q.cnt <= half_m1);
    assert_cnt_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.cnt == '0);
endmodule

// File: rtl/spi_pscl_level.sv
module spi_pscl_level (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wrap,
    input  logic cpol,
    output logic sck,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic sck;
        logic rise;
        logic fall;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!run) begin
            st_d.sck = cpol;
        end else if (wrap) begin
            st_d.sck  = ~st_q.sck;
            st_d.rise = ~st_q.sck;
            st_d.fall = st_q.sck;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck  = st_q.sck;
    assign rise = st_q.rise;
    assign fall = st_q.fall;

    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sck == $past(cpol)) && !rise && !fall);
    assert_rise_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> sck);
    assert_fall_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !sck);
    assert_edge_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
    import spi_pscl_pkg::*;
#(
    parameter int DIV_EXP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [PSC_PM_W-1:0] cfg_pm,
    input  logic                cfg_fast,
    input  logic                cfg_div16,
    input  logic                cfg_cpol,
    output logic                half_tick,
    output logic                sck,
    output logic                rise_tick,
    output logic                fall_tick
);
    localparam int CNT_W = PSC_PM_W + DIV_EXP + 2;

    pscl_cfg_t        cfg_d, cfg_q;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    always_comb begin
        cfg_d = cfg_q;
        if (!run) begin
            cfg_d.pm    = cfg_pm;
            cfg_d.fast  = cfg_fast;
            cfg_d.div16 = cfg_div16;
            cfg_d.cpol  = cfg_cpol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    spi_pscl_ratio #(.DIV_EXP(DIV_EXP), .CNT_W(CNT_W)) i_ratio (
        .cfg     (cfg_q),
        .half_m1 (half_m1)
    );

    spi_pscl_counter #(.CNT_W(CNT_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .half_m1 (half_m1),
        .wrap    (wrap),
        .tick    (half_tick)
    );

    spi_pscl_level i_level (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .wrap  (wrap),
        .cpol  (cfg_cpol),
        .sck   (sck),
        .rise  (rise_tick),
        .fall  (fall_tick)
    );

    assert_tick_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run && wrap |=> half_tick && (sck != $past(sck)));
    assert_hold_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run && !wrap |=> !half_tick && $stable(sck));
    assert_edges_match_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick == (rise_tick || fall_tick));
endmodule

// File: tb/test_spi_sck_prescaler.sv
module test_spi_sck_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [3:0] cfg_pm = '0;
    logic       cfg_fast = 1'b0;
    logic       cfg_div16 = 1'b0;
    logic       cfg_cpol = 1'b0;
    logic       half_tick, sck, rise_tick, fall_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference model state
    int m_cnt = 0, m_pm = 0, m_fast = 0, m_div = 0;
    bit m_sck = 0, m_tick = 0, m_rise = 0, m_fall = 0;

    always #2.5 clk = ~clk;

    spi_sck_prescaler i_spi_sck_prescaler (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_pm(cfg_pm),
        .cfg_fast(cfg_fast), .cfg_div16(cfg_div16), .cfg_cpol(cfg_cpol),
        .half_tick(half_tick), .sck(sck), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    function automatic int half_of(int pm, int fast, int dv);
        int h;
        h = fast ? (pm + 1) : 2 * (pm + 1);
        if (dv != 0) h = h * 16;
        return h;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_sck = 0; m_tick = 0; m_rise = 0; m_fall = 0;
            m_pm = 0; m_fast = 0; m_div = 0;
        end else if (!run) begin
            m_cnt = 0; m_sck = cfg_cpol; m_tick = 0; m_rise = 0; m_fall = 0;
            m_pm = cfg_pm; m_fast = cfg_fast; m_div = cfg_div16;
        end else begin
            m_tick = 0; m_rise = 0; m_fall = 0;
            if (m_cnt == half_of(m_pm, m_fast, m_div) - 1) begin
                m_cnt = 0; m_sck = !m_sck; m_tick = 1;
                m_rise = m_sck; m_fall = !m_sck;
            end else begin
                m_cnt++;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R6 tick", half_tick, m_tick);
            check("R2/R6 sck", sck, m_sck);
            check("R7 rise", rise_tick, m_rise);
            check("R7 fall", fall_tick, m_fall);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic setup(int pm, int fast, int dv, int cpol);
        @(negedge clk);
        run = 0; cfg_pm = 4'(pm); cfg_fast = 1'(fast); cfg_div16 = 1'(dv); cfg_cpol = 1'(cpol);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Raise run and count clocks to the first tick (R8), then measure gaps.
    task automatic measure(string req, int h, int gaps);
        int k;
        run = 1;
        k = 0;
        do begin @(negedge clk); k++; end while (!half_tick && k < 2000);
        check({req, " R8 first"}, k, h);
        for (int g = 0; g < gaps; g++) begin
            k = 0;
            do begin @(negedge clk); k++; end while (!half_tick && k < 2000);
            check({req, " gap"}, k, h);
        end
    endtask

    initial begin
        int k;
        #1;
        check("R1 sck", sck, 0);
        check("R1 tick", half_tick, 0);
        check("R1 rise", rise_tick, 0);
        check("R1 fall", fall_tick, 0);
        @(negedge clk); rst_n = 1;
        cfg_cpol = 1;
        @(negedge clk);
        check("R2 idle cpol=1", sck, 1);
        check("R2 no tick", half_tick, 0);

        setup(0, 0, 0, 0);  measure("R3 pm0", 2, 4);
        setup(3, 0, 0, 1);  measure("R3 pm3", 8, 3);
        setup(0, 1, 0, 0);  measure("R4 pm0", 1, 5);
        setup(15, 1, 0, 1); measure("R4 pm15", 16, 2);
        setup(1, 1, 1, 0);  measure("R5 fast", 32, 2);
        setup(15, 0, 1, 0); measure("R5 max", 512, 2);

        // R9: drop run mid-period, restart needs a full half period
        setup(4, 0, 0, 0);
        run = 1;
        repeat (5) @(negedge clk);
        check("R9 no early tick", half_tick, 0);
        run = 0;
        @(negedge clk);
        check("R9 idle level", sck, 0);
        measure("R9 restart", 10, 1);

        // R10: configuration changes while running are ignored
        setup(2, 1, 0, 0);
        run = 1;
        @(negedge clk);
        cfg_pm = 4'd9; cfg_fast = 0; cfg_div16 = 1; cfg_cpol = 1;
        k = 1;
        while (!half_tick && k < 2000) begin @(negedge clk); k++; end
        check("R10 first", k, 3);
        for (int g = 0; g < 3; g++) begin
            k = 0;
            do begin @(negedge clk); k++; end while (!half_tick && k < 2000);
            check("R10 gap", k, 3);
        end
        run = 0;
        @(negedge clk);
        check("R2 new cpol", sck, 1);
        measure("R10 new cfg", 320, 1);
        run = 0;
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule